// File: doc/BRIEF.md
# Transmit Retry and Defer Status

This block records how a single outgoing Ethernet frame fared on the wire. Each collision increments a 4-bit retry counter. The counter stops at its top value. A 16th failed attempt marks the frame as abandoned and raises a retry-exhausted flag. A separate timer counts bit times while the frame waits for the carrier to clear. If the wait runs past a fixed limit, an excessive-defer flag is set. The default limit is 24288 bit times, which is two maximum-length frames.

The host sees a single read-only status byte. It carries the excessive-defer flag and the retry count, and it holds these values until the host acknowledges the frame. When a frame either completes or is abandoned, the block raises status-valid and pulses a transmit interrupt. The host is expected to read the status byte first and then issue the frame-status read. A frame-status read issued while status-valid is high clears the count, both flags and status-valid together. The byte has no write path, so software can never alter it.

Top module: `tx_attempt_status`

## Requirements
- R1: Each `collision_i` pulse adds one to the retry count in bits 3:0 of `retry_byte_o`, visible the cycle after. A frame whose first attempt succeeds reports a count of 0.
- R2: The retry count saturates at 15. Further collisions leave it at 15.
- R3: A collision while the count is already 15 is the 16th failed attempt. On the next cycle it sets `retry_exhausted_o` and `status_valid_o`.
- R4: `retry_byte_o` layout: bit 7 is the excessive-defer flag, bits 6:4 always read 0, and bits 3:0 hold the retry count.
- R5: `rd_fstat_i` while `status_valid_o` is high clears the retry count, the excessive-defer flag, `retry_exhausted_o` and `status_valid_o` on the next cycle. `rd_fstat_i` while `status_valid_o` is low has no effect.
- R6: The defer timer counts `bit_tick_i` only while `defer_i` is high and no `attempt_start_i` has been seen since the last `frame_load_i`. `frame_load_i` resets it. The excessive-defer flag sets on the tick that would carry the count beyond `DEFER_LIMIT`, which is tick number `DEFER_LIMIT`+1.
- R7: `success_i`, or the exhaustion of R3, sets `status_valid_o`. If status-valid was low, `tx_irq_o` pulses for exactly one cycle at the same time.
- R8: Reset (`rst_ni` low) clears the retry count, both flags, `status_valid_o` and `tx_irq_o`.
- R9: Once set, the excessive-defer flag persists across `frame_load_i` until it is cleared as described in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_load_i | input | 1 | New frame loaded; resets the defer timer |
| attempt_start_i | input | 1 | Transmission attempt begins |
| collision_i | input | 1 | Attempt ended in collision |
| success_i | input | 1 | Frame transmitted successfully |
| defer_i | input | 1 | Transmission held off by carrier |
| bit_tick_i | input | 1 | One pulse per bit time |
| rd_fstat_i | input | 1 | Host reads frame status |
| retry_byte_o | output | 8 | Excessive-defer flag, reserved zeros, retry count |
| retry_exhausted_o | output | 1 | All 16 attempts failed |
| status_valid_o | output | 1 | Frame outcome available |
| tx_irq_o | output | 1 | One-cycle transmit interrupt |

## Verification
The bench builds the block with `DEFER_LIMIT` set to 4. This puts the boundary between the last permitted defer tick and the first excessive one within a few cycles. The retry field stays at its fixed 4-bit width, so the bench drives saturation at 15 and the abandoning 16th collision directly. The interplay of frame loads, attempt starts and carrier deferral on the timer is reachable in short sequences.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int RETRY_W  = 4;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic               excess_defer;
    logic [2:0]         zero;
    logic [RETRY_W-1:0] retry;
  } txs_status_t;
endpackage

// File: rtl/txs_retry_ctr.sv
module txs_retry_ctr
  import txs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               coll_i,
  output logic [RETRY_W-1:0] cnt_o,
  output logic               exhaust_o
);
  localparam logic [RETRY_W-1:0] MAX_CNT = {RETRY_W{1'b1}};

  logic [RETRY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (coll_i && cnt_q != MAX_CNT) cnt_q <= cnt_q + 1'b1;
  end

  // collision at full count = final failed attempt
  assign exhaust_o = coll_i && !clr_i && (cnt_q == MAX_CNT);
  assign cnt_o     = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_CNT && !clr_i) |=> cnt_q == MAX_CNT); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && !clr_i && cnt_q != MAX_CNT) |=> cnt_q != '0); // R1
endmodule

// File: rtl/txs_defer_timer.sv
module txs_defer_timer #(
  parameter int DEFER_LIMIT = 24288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic start_i,
  input  logic defer_i,
  input  logic tick_i,
  output logic over_o
);
  localparam int            CNT_W = $clog2(DEFER_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DEFER_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             started_q;
  logic             counting;

  assign counting = defer_i && tick_i && !started_q && !load_i;
  assign over_o   = counting && (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      if (start_i) started_q <= 1'b1;
      if (counting && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_LOAD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == '0); // R6
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(defer_i && tick_i)) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tx_attempt_status.sv
module tx_attempt_status
  import txs_pkg::*;
#(
  parameter int DEFER_LIMIT = 24288
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_load_i,
  input  logic                attempt_start_i,
  input  logic                collision_i,
  input  logic                success_i,
  input  logic                defer_i,
  input  logic                bit_tick_i,
  input  logic                rd_fstat_i,
  output logic [STATUS_W-1:0] retry_byte_o,
  output logic                retry_exhausted_o,
  output logic                status_valid_o,
  output logic                tx_irq_o
);
  logic [RETRY_W-1:0] retry_cnt;
  logic               exhaust, over;
  logic               valid_q, exh_q, excess_q, irq_q;
  logic               rd_clr, done;
  txs_status_t        stat;

  assign rd_clr = rd_fstat_i && valid_q;
  assign done   = success_i || exhaust;

  txs_retry_ctr i_retry_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rd_clr),
    .coll_i    (collision_i),
    .cnt_o     (retry_cnt),
    .exhaust_o (exhaust)
  );

  txs_defer_timer #(.DEFER_LIMIT(DEFER_LIMIT)) i_defer_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (frame_load_i),
    .start_i (attempt_start_i),
    .defer_i (defer_i),
    .tick_i  (bit_tick_i),
    .over_o  (over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      exh_q    <= 1'b0;
      excess_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (rd_clr) begin
      valid_q  <= 1'b0;
      exh_q    <= 1'b0;
      excess_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (exhaust) exh_q    <= 1'b1;
      if (over)    excess_q <= 1'b1;
      if (done)    valid_q  <= 1'b1;
      irq_q <= done && !valid_q;
    end
  end

  always_comb begin
    stat.excess_defer = excess_q;
    stat.zero         = '0;
    stat.retry        = retry_cnt;
  end

  assign retry_byte_o      = stat;
  assign retry_exhausted_o = exh_q;
  assign status_valid_o    = valid_q;
  assign tx_irq_o          = irq_q;

  AST_EXH_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retry_exhausted_o) |-> (retry_byte_o[3:0] == 4'hF && status_valid_o)); // R3
  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fstat_i && status_valid_o) |=> (retry_byte_o == '0 && !status_valid_o && !retry_exhausted_o)); // R5
  AST_IRQ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (status_valid_o && !$past(status_valid_o))); // R7
  AST_EXCESS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_byte_o[7] && !(rd_fstat_i && status_valid_o)) |=> retry_byte_o[7]); // R9
endmodule

// File: tb/test_tx_attempt_status.sv
module test_tx_attempt_status;
  localparam int LIMIT = 4;
  // stim bits: {load,start,coll,succ,defer,tick,rdf}
  localparam logic [6:0] S_LOAD = 7'h40, S_START = 7'h20, S_COLL = 7'h10,
                         S_SUCC = 7'h08, S_DEFT = 7'h06, S_DEF = 7'h04,
                         S_TICK = 7'h02, S_RDF = 7'h01, S_IDLE = 7'h00;
  localparam int NV = 20;
  // {stim[6:0], byte[7:0], valid, exh, irq}
  localparam logic [17:0] VEC [NV] = '{
    {S_LOAD,  8'h00, 3'b000},
    {S_DEFT,  8'h00, 3'b000},
    {S_DEFT,  8'h00, 3'b000},
    {S_DEFT,  8'h00, 3'b000},
    {S_DEFT,  8'h00, 3'b000},
    {S_DEF,   8'h00, 3'b000},
    {S_DEFT,  8'h80, 3'b000},
    {S_START, 8'h80, 3'b000},
    {S_COLL,  8'h81, 3'b000},
    {S_COLL,  8'h82, 3'b000},
    {S_START, 8'h82, 3'b000},
    {S_SUCC,  8'h82, 3'b101},
    {S_IDLE,  8'h82, 3'b100},
    {S_RDF,   8'h00, 3'b000},
    {S_LOAD,  8'h00, 3'b000},
    {S_SUCC,  8'h00, 3'b101},
    {S_RDF,   8'h00, 3'b000},
    {S_COLL,  8'h01, 3'b000},
    {S_RDF,   8'h01, 3'b000},
    {S_TICK,  8'h01, 3'b000}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] stim = '0;
  logic [7:0] retry_byte_o;
  logic       retry_exhausted_o, status_valid_o, tx_irq_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  tx_attempt_status #(.DEFER_LIMIT(LIMIT)) i_tx_attempt_status (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .frame_load_i      (stim[6]),
    .attempt_start_i   (stim[5]),
    .collision_i       (stim[4]),
    .success_i         (stim[3]),
    .defer_i           (stim[2]),
    .bit_tick_i        (stim[1]),
    .rd_fstat_i        (stim[0]),
    .retry_byte_o      (retry_byte_o),
    .retry_exhausted_o (retry_exhausted_o),
    .status_valid_o    (status_valid_o),
    .tx_irq_o          (tx_irq_o)
  );

  task automatic cyc(input logic [6:0] s);
    stim = s;
    @(posedge clk_i);
    #1;
    stim = '0;
  endtask

  task automatic chk(input string req, input logic [7:0] eb, input logic [2:0] evei);
    checks++;
    if (retry_byte_o !== eb || {status_valid_o, retry_exhausted_o, tx_irq_o} !== evei) begin
      errors++;
      $display("FAIL %s: byte=%h v/e/i=%b expected byte=%h v/e/i=%b",
               req, retry_byte_o, {status_valid_o, retry_exhausted_o, tx_irq_o}, eb, evei);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R8 reset state", 8'h00, 3'b000);

    // table: R1 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k][17:11]);
      chk($sformatf("R1/R4/R5/R6/R7 row %0d", k), VEC[k][10:3], VEC[k][2:0]);
    end

    // R2 R3: saturation and exhaustion
    do_reset();
    for (int k = 0; k < 15; k++) cyc(S_COLL);
    chk("R2 count reaches 15", 8'h0F, 3'b000);
    cyc(S_COLL);
    chk("R3 16th failure", 8'h0F, 3'b111);
    cyc(S_COLL);
    chk("R2 saturated", 8'h0F, 3'b110);
    cyc(S_RDF);
    chk("R5 clear on read", 8'h00, 3'b000);

    // R6: load resets timer
    cyc(S_LOAD);
    for (int k = 0; k < 3; k++) cyc(S_DEFT);
    cyc(S_LOAD);
    for (int k = 0; k < LIMIT; k++) cyc(S_DEFT);
    chk("R6 load restarts timer", 8'h00, 3'b000);
    cyc(S_DEFT);
    chk("R6 limit exceeded", 8'h80, 3'b000);

    // R9: persists across load; R5 read without valid ignored
    cyc(S_LOAD);
    chk("R9 persists over load", 8'h80, 3'b000);
    cyc(S_RDF);
    chk("R5 read while not valid", 8'h80, 3'b000);
    cyc(S_SUCC);
    cyc(S_RDF);
    chk("R5 clears excess", 8'h00, 3'b000);

    // R6: start freezes timer; tick without defer ignored
    cyc(S_LOAD);
    cyc(S_START);
    for (int k = 0; k < LIMIT + 2; k++) cyc(S_DEFT);
    chk("R6 frozen after start", 8'h00, 3'b000);
    cyc(S_LOAD);
    for (int k = 0; k < LIMIT + 2; k++) cyc(S_TICK);
    chk("R6 no count without defer", 8'h00, 3'b000);

    // R8: reset mid-frame
    cyc(S_COLL);
    cyc(S_SUCC);
    chk("R7 valid with count", 8'h01, 3'b101);
    do_reset();
    chk("R8 reset clears", 8'h00, 3'b000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule